// File: doc/BRIEF.md
# Programmable Parallel I/O Controller

This block connects a CPU to three 8-bit parallel ports, A, B and C, through an 8-bit data bus. The bus has an active-low chip select, active-low read and write strobes, and a 2-bit address. The bidirectional data bus is split into an input, an output and an output enable. Each port has its own pin input, output latch and output enable toward the pads. Port C is split into two nibbles that are steered separately: the upper nibble belongs to group A, together with port A, and the lower nibble belongs to group B, together with port B.

Software programs the block through the control address. A write with bit 7 set is a mode set: it fixes the direction of each group slice and clears every output latch. A write with bit 7 clear is a single-bit command: it forces one port C bit to 0 or 1 and leaves the mode untouched. Only basic input/output operation is built. Writes are synchronous and take effect at the rising clock edge where chip select and write are both low. Reads are combinational while chip select and read are both low.

Top module: `ppi_ctrl`

## Requirements
- R1: While rst_ni is low, the control word becomes 9Bh and every port output latch is cleared to 0. After reset every pin output enable is 0.
- R2: data_oe_o is 1 only while cs_ni and rd_ni are both 0. Otherwise it is 0.
- R3: addr_i selects the target: 00 is port A, 01 is port B, 10 is port C and 11 is the control word. A port write loads data_i into that port's latch at the rising edge where cs_ni and wr_ni are both 0.
- R4: A control write with bit 7 = 1 stores the word. The direction bits are bit 4 for port A, bit 3 for port C bits 7..4, bit 1 for port B and bit 0 for port C bits 3..0. A value of 1 means input (enable 0) and 0 means output (enable 1).
- R5: A read of the control address returns bit 7 as 1 and bits 6..0 as last stored.
- R6: A mode-set write clears the port A, B and C output latches to 0.
- R7: A control write with bit 7 = 0 loads bit 0 into port C bit number data_i[3:1]. All other port C bits and the stored control word are unchanged.
- R8: Reading a port returns the live pins for bits configured as input and the output latch for bits configured as output. For port C this is decided per nibble.
- R9: A write to a port configured as input still updates its latch, which is visible on the port output, while that port's output enable stays 0.
- R10: A write strobe with cs_ni = 1 changes no latch and no control state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 2 | Target select |
| data_i | input | 8 | Write data from the CPU |
| data_o | output | 8 | Read data to the CPU |
| data_oe_o | output | 1 | Data bus drive enable |
| pa_i | input | 8 | Port A pins in |
| pa_o | output | 8 | Port A latch |
| pa_oe_o | output | 1 | Port A drive enable |
| pb_i | input | 8 | Port B pins in |
| pb_o | output | 8 | Port B latch |
| pb_oe_o | output | 1 | Port B drive enable |
| pc_i | input | 8 | Port C pins in |
| pc_o | output | 8 | Port C latch |
| pc_oe_o | output | 8 | Port C per-bit drive enable |

## Verification
Directed sequences cover the following cases:
- the reset word;
- a write to an input port followed by a switch to output;
- a single-bit command on every index, which separates index decoding from value handling;
- a write with chip select high.

A seeded random mix of mode sets, port writes, bit commands and reads then runs against a bench model, with new pin values on every read. The changing pin values tell whether a read returns the pins or the latch, nibble by nibble. The random mode words tell whether each group follows its own direction bits.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int DW = 8;
  localparam int IW = $clog2(DW);
  localparam logic [DW-1:0] CW_RESET = 8'h9B;

  typedef enum logic [1:0] {
    SEL_PA  = 2'b00,
    SEL_PB  = 2'b01,
    SEL_PC  = 2'b10,
    SEL_CTL = 2'b11
  } sel_e;

  typedef struct packed {
    logic pa_in;
    logic pcu_in;
    logic pb_in;
    logic pcl_in;
  } dir_t;
endpackage

// File: rtl/ppi_bus_dec.sv
module ppi_bus_dec
  import ppi_pkg::*;
(
  input  logic       cs_ni,
  input  logic       rd_ni,
  input  logic       wr_ni,
  input  logic [1:0] addr_i,
  output logic       rd_act_o,
  output logic       wr_act_o,
  output logic [3:0] sel_o
);
  assign rd_act_o = !cs_ni && !rd_ni;
  assign wr_act_o = !cs_ni && !wr_ni;

  for (genvar i = 0; i < 4; i++) begin : g_sel
    assign sel_o[i] = (addr_i == 2'(i));
  end
endmodule

// File: rtl/ppi_ctrl_reg.sv
module ppi_ctrl_reg
  import ppi_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cw_o,
  output dir_t          dir_o,
  output logic          mode_set_o,
  output logic          bit_we_o,
  output logic [IW-1:0] bit_idx_o,
  output logic          bit_val_o
);
  logic [DW-1:0] cw_q;

  assign mode_set_o = we_i && wdata_i[7];
  assign bit_we_o   = we_i && !wdata_i[7];
  assign bit_idx_o  = wdata_i[3:1];
  assign bit_val_o  = wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cw_q <= CW_RESET;
    else if (mode_set_o) cw_q <= wdata_i;
  end

  assign cw_o  = {1'b1, cw_q[6:0]};
  assign dir_o = '{pa_in: cw_q[4], pcu_in: cw_q[3], pb_in: cw_q[1], pcl_in: cw_q[0]};
endmodule

// File: rtl/ppi_port_latch.sv
module ppi_port_latch #(
  parameter int W  = 8,
  parameter int XW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          bit_we_i,
  input  logic [XW-1:0] bit_idx_i,
  input  logic          bit_val_i,
  output logic [W-1:0]  q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= '0;
    else if (clr_i)    q <= '0;
    else if (we_i)     q <= wdata_i;
    else if (bit_we_i) q[bit_idx_i] <= bit_val_i;
  end

  assign q_o = q;
endmodule

// File: rtl/ppi_ctrl.sv
module ppi_ctrl
  import ppi_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_ni,
  input  logic         rd_ni,
  input  logic         wr_ni,
  input  logic [1:0]   addr_i,
  input  logic [7:0]   data_i,
  output logic [7:0]   data_o,
  output logic         data_oe_o,
  input  logic [7:0]   pa_i,
  output logic [7:0]   pa_o,
  output logic         pa_oe_o,
  input  logic [7:0]   pb_i,
  output logic [7:0]   pb_o,
  output logic         pb_oe_o,
  input  logic [7:0]   pc_i,
  output logic [7:0]   pc_o,
  output logic [7:0]   pc_oe_o
);
  localparam int NH = DW / 2;

  logic          rd_act, wr_act;
  logic [3:0]    sel;
  logic [DW-1:0] cw;
  dir_t          dir;
  logic          mode_set, bit_we, bit_val;
  logic [IW-1:0] bit_idx;
  logic [DW-1:0] la, lb, lc, pc_rd;
  logic [1:0]    pc_nib_in;

  ppi_bus_dec u_dec (
    .cs_ni(cs_ni), .rd_ni(rd_ni), .wr_ni(wr_ni), .addr_i(addr_i),
    .rd_act_o(rd_act), .wr_act_o(wr_act), .sel_o(sel)
  );

  ppi_ctrl_reg u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(wr_act && sel[SEL_CTL]), .wdata_i(data_i),
    .cw_o(cw), .dir_o(dir), .mode_set_o(mode_set),
    .bit_we_o(bit_we), .bit_idx_o(bit_idx), .bit_val_o(bit_val)
  );

  ppi_port_latch #(.W(DW)) u_pa (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(mode_set),
    .we_i(wr_act && sel[SEL_PA]), .wdata_i(data_i),
    .bit_we_i(1'b0), .bit_idx_i('0), .bit_val_i(1'b0), .q_o(la)
  );

  ppi_port_latch #(.W(DW)) u_pb (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(mode_set),
    .we_i(wr_act && sel[SEL_PB]), .wdata_i(data_i),
    .bit_we_i(1'b0), .bit_idx_i('0), .bit_val_i(1'b0), .q_o(lb)
  );

  ppi_port_latch #(.W(DW)) u_pc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(mode_set),
    .we_i(wr_act && sel[SEL_PC]), .wdata_i(data_i),
    .bit_we_i(bit_we), .bit_idx_i(bit_idx), .bit_val_i(bit_val), .q_o(lc)
  );

  // nibble 0 = group B (lower), nibble 1 = group A (upper)
  assign pc_nib_in = {dir.pcu_in, dir.pcl_in};
  for (genvar n = 0; n < 2; n++) begin : g_pc_nib
    assign pc_oe_o[n*NH +: NH] = {NH{!pc_nib_in[n]}};
    assign pc_rd[n*NH +: NH]   = pc_nib_in[n] ? pc_i[n*NH +: NH] : lc[n*NH +: NH];
  end

  assign pa_o    = la;
  assign pb_o    = lb;
  assign pc_o    = lc;
  assign pa_oe_o = !dir.pa_in;
  assign pb_oe_o = !dir.pb_in;

  always_comb begin
    unique case (addr_i)
      SEL_PA:  data_o = dir.pa_in ? pa_i : la;
      SEL_PB:  data_o = dir.pb_in ? pb_i : lb;
      SEL_PC:  data_o = pc_rd;
      default: data_o = cw;
    endcase
  end

  assign data_oe_o = rd_act;
endmodule

// File: rtl/ppi_ctrl_chk.sv
module ppi_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       rd_ni,
  input logic       wr_ni,
  input logic [1:0] addr_i,
  input logic [7:0] data_i,
  input logic [7:0] data_o,
  input logic       data_oe_o,
  input logic [7:0] pa_o,
  input logic       pa_oe_o,
  input logic [7:0] pb_o,
  input logic       pb_oe_o,
  input logic [7:0] pc_o,
  input logic [7:0] pc_oe_o
);
  logic wr_ok;
  assign wr_ok = rst_ni && !cs_ni && !wr_ni;

  AST_BUS_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || rd_ni) |-> !data_oe_o); // R2

  AST_CW_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && addr_i == 2'b11) |-> data_o[7]); // R5

  AST_PA_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_ok && addr_i == 2'b00) |-> pa_o == $past(data_i)); // R3

  AST_MODE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_ok && addr_i == 2'b11 && data_i[7]) |-> (pa_o == 8'h00 && pb_o == 8'h00 && pc_o == 8'h00)); // R6

  AST_BIT_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_ok && addr_i == 2'b11 && !data_i[7]) |->
      (pc_o[$past(data_i[3:1])] == $past(data_i[0]) && $stable(pa_oe_o) && $stable(pb_oe_o) && $stable(pc_oe_o))); // R7

  AST_NO_CS_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && cs_ni) |-> ($stable(pa_o) && $stable(pb_o) && $stable(pc_o) && $stable(pa_oe_o) && $stable(pb_oe_o) && $stable(pc_oe_o))); // R10
endmodule

bind ppi_ctrl ppi_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
  .addr_i(addr_i), .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o),
  .pa_o(pa_o), .pa_oe_o(pa_oe_o), .pb_o(pb_o), .pb_oe_o(pb_oe_o),
  .pc_o(pc_o), .pc_oe_o(pc_oe_o)
);

// File: tb/ppi_ctrl_tb.sv
module ppi_ctrl_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst_ni = 0;
  logic cs_ni = 1, rd_ni = 1, wr_ni = 1;
  logic [1:0] addr = 0;
  logic [7:0] din = 0, dout, pa_i = 0, pb_i = 0, pc_i = 0, pa_o, pb_o, pc_o, pc_oe;
  logic doe, pa_oe, pb_oe;
  int checks = 0, errors = 0;
  logic [7:0] m_cw, m_a, m_b, m_c;

  always #(CLK_P/2) clk = ~clk;

  ppi_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(doe),
    .pa_i(pa_i), .pa_o(pa_o), .pa_oe_o(pa_oe), .pb_i(pb_i), .pb_o(pb_o), .pb_oe_o(pb_oe),
    .pc_i(pc_i), .pc_o(pc_o), .pc_oe_o(pc_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    logic [7:0] r;
    case (a)
      2'b00: r = m_cw[4] ? pa_i : m_a;
      2'b01: r = m_cw[1] ? pb_i : m_b;
      2'b10: begin
        r[7:4] = m_cw[3] ? pc_i[7:4] : m_c[7:4];
        r[3:0] = m_cw[0] ? pc_i[3:0] : m_c[3:0];
      end
      default: r = {1'b1, m_cw[6:0]};
    endcase
    return r;
  endfunction

  function automatic logic [9:0] exp_oe();
    return {!m_cw[4], !m_cw[1], {4{!m_cw[3]}}, {4{!m_cw[0]}}};
  endfunction

  task automatic model_write(input logic [1:0] a, input logic [7:0] d);
    case (a)
      2'b00: m_a = d;
      2'b01: m_b = d;
      2'b10: m_c = d;
      default:
        if (d[7]) begin m_cw = d; m_a = 0; m_b = 0; m_c = 0; end
        else m_c[d[3:1]] = d[0];
    endcase
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel, input string req);
    @(negedge clk);
    addr = a; din = d; cs_ni = !sel; wr_ni = 0;
    @(negedge clk);
    wr_ni = 1; cs_ni = 1;
    if (sel) model_write(a, d);
    #1;
    chk(req, {pa_o, pb_o, pc_o}, {m_a, m_b, m_c});
    chk(req, {pa_oe, pb_oe, pc_oe}, exp_oe());
  endtask

  task automatic bus_read(input logic [1:0] a, input string req);
    @(negedge clk);
    addr = a; cs_ni = 0; rd_ni = 0;
    pa_i = 8'($urandom); pb_i = 8'($urandom); pc_i = 8'($urandom);
    #(CLK_P/4);
    chk(req, {doe, dout}, {1'b1, exp_read(a)});
    @(negedge clk);
    rd_ni = 1; cs_ni = 1;
    #1;
    chk("R2", doe, 1'b0);
  endtask

  initial begin
    #(CLK_P*5000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    m_cw = 8'h9B; m_a = 0; m_b = 0; m_c = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    #1;
    // R1 reset state
    chk("R1", {pa_oe, pb_oe, pc_oe}, 10'h0);
    chk("R1", {pa_o, pb_o, pc_o}, 24'h0);
    chk("R2", doe, 1'b0);
    bus_read(2'b11, "R1 R5");
    bus_read(2'b00, "R8");
    // R9: write to input port A updates latch, no drive
    bus_write(2'b00, 8'h5A, 1'b1, "R9");
    chk("R9", {pa_o, pa_oe}, {8'h5A, 1'b0});
    // R4 R6: A out, C upper in, B out, C lower out (mode set clears latches)
    bus_write(2'b11, 8'h88, 1'b1, "R4 R6");
    chk("R6", pa_o, 8'h00);
    bus_read(2'b11, "R5");
    bus_write(2'b00, 8'hC3, 1'b1, "R3");
    bus_read(2'b00, "R8");
    bus_write(2'b10, 8'hA5, 1'b1, "R3");
    bus_read(2'b10, "R8");
    // R7 every index, set then clear
    for (int i = 0; i < 8; i++) bus_write(2'b11, 8'(i*2 + 1), 1'b1, "R7");
    chk("R7", pc_o, 8'hFF);
    for (int i = 0; i < 8; i += 2) bus_write(2'b11, 8'(i*2), 1'b1, "R7");
    chk("R7", pc_o, 8'hAA);
    bus_read(2'b11, "R7");
    // R10 writes with chip select high
    bus_write(2'b01, 8'h77, 1'b0, "R10");
    bus_write(2'b11, 8'h80, 1'b0, "R10");
    bus_write(2'b11, 8'h03, 1'b0, "R10");
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [1:0] a;
      logic [7:0] d;
      int op;
      a = 2'($urandom); d = 8'($urandom); op = int'($urandom_range(0, 9));
      if (op < 4) bus_read(a, "R8 R3");
      else if (op < 5) bus_write(a, d, 1'b0, "R10");
      else if (op < 7) bus_write(2'b11, {1'b1, d[6:0]}, 1'b1, "R4 R6");
      else bus_write(a, d, 1'b1, "R3 R7");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule